// File: doc/BRIEF.md
# Subscriber Line Transmit Framer

This block turns parallel channel data into the serial symbol stream sent on a two-wire digital subscriber line. At the start of every frame it samples a B1 byte, a B2 byte, a D-channel byte and a housekeeping bit, along with the rate, mode and D-into-B1 controls. It then shifts out one framed bit per baud and codes each bit as two half-baud line symbols.

Timing comes from `half_en_i`, a one-clock strobe that fires at twice the baud rate. Each strobe moves the output to the next half-baud. The low rate (80 kbit/s) uses a 10-baud frame and the high rate (160 kbit/s) uses a 20-baud frame. In framed mode the frame carries a toggling sync bit so the far end can find the frame boundary. In unframed mode every baud carries payload. A disable pin and a diagnostic control can each force the line to its idle bias level at any time.

Top module: `dslf_line_tx`

## Requirements
- R1: After reset, and until the first `half_en_i` strobe, `sym_o` is 2'b00 (idle) and `frame_start_o` is 0.
- R2: Symbol codes are 2'b00 idle, 2'b01 low and 2'b10 high. A 1 is sent as low then high, and a 0 is sent as high then low. Each half lasts from one `half_en_i` strobe to the next, so the level always flips at mid-baud.
- R3: In framed mode at the low rate (`rate_hi_i`=0, `unframed_i`=0), the frame has 10 bauds in this order: sync, `d_chan_i[0]`, then `b1_i` MSB first.
- R4: In framed mode at the high rate, the frame has 20 bauds in this order: sync, `hk_i`, `d_chan_i[1]`, `d_chan_i[0]`, then `b1_i` MSB first, then `b2_i` MSB first.
- R5: In framed mode with `d_in_b1_i`=1, the B1 slot carries `d_chan_i[7:0]` MSB first and the dedicated D positions carry 0.
- R6: In unframed mode the low-rate frame is `d_chan_i[1]`, `d_chan_i[0]`, then `b1_i` MSB first (10 bauds). The high-rate frame is `d_chan_i[3:0]` MSB first, then `b1_i`, then `b2_i` (20 bauds). `d_in_b1_i` has no effect in this mode.
- R7: The sync bit is 1 in the first frame after reset and inverts in every later frame.
- R8: All data and control inputs are sampled only on the strobe that starts a frame. Changes made during a frame do not alter that frame's bits or its length.
- R9: `frame_start_o` is high for exactly the one clock that follows the strobe that starts a frame. At that time the first half of the frame's first baud is on `sym_o`.
- R10: While `line_dis_i` or `diag_off_i` is 1, `sym_o` is 2'b00 in the same cycle. Framing keeps running underneath, and on release the output continues at the current frame position.
- R11: On clocks without `half_en_i`, `sym_o` and the frame position hold, and `frame_start_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_en_i | input | 1 | Half-baud strobe (twice the baud rate) |
| rate_hi_i | input | 1 | 1 selects the 20-baud (160 kbit/s) frame, 0 the 10-baud frame |
| unframed_i | input | 1 | 1 selects the continuous data mode with no sync, HK or D overhead |
| d_in_b1_i | input | 1 | Sends the whole D byte in the B1 slot (framed mode) |
| hk_i | input | 1 | Housekeeping bit |
| d_chan_i | input | 8 | D-channel bits for the frame |
| b1_i | input | 8 | B1 channel byte |
| b2_i | input | 8 | B2 channel byte |
| line_dis_i | input | 1 | Forces the line to idle |
| diag_off_i | input | 1 | Diagnostic control that forces the line to idle |
| sym_o | output | 2 | Line symbol: 00 idle, 01 low, 10 high |
| frame_start_o | output | 1 | One-clock pulse at the start of each frame |

## Verification
The bench sweeps every combination of rate, mode and D-into-B1 against a set of byte patterns. Each half-baud is compared with a frame image the bench builds itself, so a swapped field order, a wrong D bit or an inverted transition polarity all show up as a wrong symbol at a specific baud. Some frames change their inputs mid-frame. A design that samples live inputs, or that picks up a new rate at once, then emits the wrong bits or a frame of the wrong length. Uneven gaps between strobes expose a design that advances without a strobe. Disable pulses placed mid-frame catch an output that is not forced to idle, and also catch framing that stalls or slips while the line is off.

// File: rtl/dslf_pkg.sv
package dslf_pkg;
  typedef enum logic [1:0] {
    SYM_IDLE = 2'b00,
    SYM_LOW  = 2'b01,
    SYM_HIGH = 2'b10
  } sym_e;
endpackage

// File: rtl/dslf_frame_build.sv
module dslf_frame_build #(
  parameter int CH_W = 8,
  parameter int FW   = 2 * CH_W + 4,
  parameter int CW   = $clog2(FW + 1)
) (
  input  logic            rate_hi_i,
  input  logic            unframed_i,
  input  logic            d_in_b1_i,
  input  logic            sync_i,
  input  logic            hk_i,
  input  logic [CH_W-1:0] d_chan_i,
  input  logic [CH_W-1:0] b1_i,
  input  logic [CH_W-1:0] b2_i,
  output logic [FW-1:0]   word_o,
  output logic [CW-1:0]   len_o
);
  localparam int LO_LEN = CH_W + 2;
  localparam int PAD_W  = FW - LO_LEN;

  logic [CH_W-1:0] slot;
  logic [1:0]      dpair;

  always_comb begin
    slot  = d_in_b1_i ? d_chan_i : b1_i;
    dpair = d_in_b1_i ? 2'b00 : d_chan_i[1:0];
    unique case ({rate_hi_i, unframed_i})
      2'b00:   word_o = {sync_i, dpair[0], slot, {PAD_W{1'b0}}};
      2'b10:   word_o = {sync_i, hk_i, dpair, slot, b2_i};
      2'b01:   word_o = {d_chan_i[1:0], b1_i, {PAD_W{1'b0}}};
      default: word_o = {d_chan_i[3:0], b1_i, b2_i};
    endcase
    len_o = rate_hi_i ? CW'(FW) : CW'(LO_LEN);
  end
endmodule

// File: rtl/dslf_seq.sv
module dslf_seq #(
  parameter int FW = 20,
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          half_en_i,
  input  logic [FW-1:0] word_i,
  input  logic [CW-1:0] len_i,
  output logic          load_o,
  output logic          bit_o,
  output logic          phase_o,
  output logic          started_o,
  output logic [CW-1:0] idx_o,
  output logic [CW-1:0] len_o,
  output logic          fs_o
);
  logic          started_q, phase_q, fs_q;
  logic [CW-1:0] idx_q, len_q;
  logic [FW-1:0] sh_q;
  logic          last;

  assign last   = (idx_q == len_q - 1'b1);
  assign load_o = half_en_i && (!started_q || (phase_q && last));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      phase_q   <= 1'b0;
      fs_q      <= 1'b0;
      idx_q     <= '0;
      len_q     <= '0;
      sh_q      <= '0;
    end else begin
      fs_q <= load_o;
      if (load_o) begin
        started_q <= 1'b1;
        phase_q   <= 1'b0;
        idx_q     <= '0;
        len_q     <= len_i;
        sh_q      <= word_i;
      end else if (half_en_i) begin
        if (!phase_q) begin
          phase_q <= 1'b1;
        end else begin
          phase_q <= 1'b0;
          idx_q   <= idx_q + 1'b1;
          sh_q    <= {sh_q[FW-2:0], 1'b0};
        end
      end
    end
  end

  assign bit_o     = sh_q[FW-1];
  assign phase_o   = phase_q;
  assign started_o = started_q;
  assign idx_o     = idx_q;
  assign len_o     = len_q;
  assign fs_o      = fs_q;
endmodule

// File: rtl/dslf_biphase.sv
module dslf_biphase
  import dslf_pkg::*;
(
  input  logic       active_i,
  input  logic       off_i,
  input  logic       bit_i,
  input  logic       phase_i,
  output logic [1:0] sym_o
);
  sym_e sym;

  always_comb begin
    if (!active_i || off_i) sym = SYM_IDLE;
    else if (bit_i ^ phase_i) sym = SYM_LOW;   // 1: low first; 0: low second
    else sym = SYM_HIGH;
  end

  assign sym_o = sym;
endmodule

// File: rtl/dslf_line_tx.sv
module dslf_line_tx #(
  parameter int CH_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            half_en_i,
  input  logic            rate_hi_i,
  input  logic            unframed_i,
  input  logic            d_in_b1_i,
  input  logic            hk_i,
  input  logic [CH_W-1:0] d_chan_i,
  input  logic [CH_W-1:0] b1_i,
  input  logic [CH_W-1:0] b2_i,
  input  logic            line_dis_i,
  input  logic            diag_off_i,
  output logic [1:0]      sym_o,
  output logic            frame_start_o
);
  localparam int FW = 2 * CH_W + 4;
  localparam int CW = $clog2(FW + 1);

  logic [FW-1:0] word_w;
  logic [CW-1:0] len_nxt_w, idx_w, len_w;
  logic          load_w, bit_w, phase_w, started_w, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 1'b0;
    else if (load_w) sync_q <= ~sync_q;
  end

  dslf_frame_build #(.CH_W(CH_W), .FW(FW), .CW(CW)) u_build (
    .rate_hi_i (rate_hi_i),
    .unframed_i(unframed_i),
    .d_in_b1_i (d_in_b1_i),
    .sync_i    (~sync_q),
    .hk_i      (hk_i),
    .d_chan_i  (d_chan_i),
    .b1_i      (b1_i),
    .b2_i      (b2_i),
    .word_o    (word_w),
    .len_o     (len_nxt_w)
  );

  dslf_seq #(.FW(FW), .CW(CW)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .half_en_i(half_en_i),
    .word_i   (word_w),
    .len_i    (len_nxt_w),
    .load_o   (load_w),
    .bit_o    (bit_w),
    .phase_o  (phase_w),
    .started_o(started_w),
    .idx_o    (idx_w),
    .len_o    (len_w),
    .fs_o     (frame_start_o)
  );

  dslf_biphase u_enc (
    .active_i(started_w),
    .off_i   (line_dis_i | diag_off_i),
    .bit_i   (bit_w),
    .phase_i (phase_w),
    .sym_o   (sym_o)
  );
endmodule

// File: rtl/dslf_line_tx_chk.sv
module dslf_line_tx_chk #(
  parameter int CW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          half_en_i,
  input logic          line_dis_i,
  input logic          diag_off_i,
  input logic [1:0]    sym_o,
  input logic          frame_start_o,
  input logic          started_i,
  input logic          phase_i,
  input logic [CW-1:0] idx_i,
  input logic [CW-1:0] len_i
);
  logic off;
  assign off = line_dis_i | diag_off_i;

  assert_idle_pre_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started_i |-> sym_o == 2'b00);

  assert_sym_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_o != 2'b11);

  assert_mid_flip_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_en_i && started_i && !phase_i && !off) |=> (off || sym_o != $past(sym_o)));

  assert_idx_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_i |-> idx_i < len_i);

  assert_fs_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o);

  assert_off_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off |-> sym_o == 2'b00);

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !half_en_i |=> ($stable(idx_i) && $stable(phase_i) && $stable(len_i) && !frame_start_o));
endmodule

bind dslf_line_tx dslf_line_tx_chk #(.CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .half_en_i    (half_en_i),
  .line_dis_i   (line_dis_i),
  .diag_off_i   (diag_off_i),
  .sym_o        (sym_o),
  .frame_start_o(frame_start_o),
  .started_i    (started_w),
  .phase_i      (phase_w),
  .idx_i        (idx_w),
  .len_i        (len_w)
);

// File: tb/tb_dslf_line_tx.sv
module tb_dslf_line_tx;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       half_en = 1'b0, rate_hi = 1'b0, unframed = 1'b0, d_in_b1 = 1'b0, hk = 1'b0;
  logic [7:0] d_chan = '0, b1 = '0, b2 = '0;
  logic       line_dis = 1'b0, diag_off = 1'b0;
  logic [1:0] sym;
  logic       fs;

  int n_chk = 0, n_fail = 0, gap_ctr = 0;

  // reference timing model
  bit         m_started = 0, m_phase = 0, m_sync = 0, m_fs = 0, m_mod = 0;
  int         m_idx = 0, m_len = 0;
  logic [19:0] m_word = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dslf_line_tx dut (
    .clk_i(clk), .rst_ni(rst_ni), .half_en_i(half_en), .rate_hi_i(rate_hi),
    .unframed_i(unframed), .d_in_b1_i(d_in_b1), .hk_i(hk), .d_chan_i(d_chan),
    .b1_i(b1), .b2_i(b2), .line_dis_i(line_dis), .diag_off_i(diag_off),
    .sym_o(sym), .frame_start_o(fs)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [19:0] build(bit rh, bit md, bit dinb, bit s, bit h,
                                        logic [7:0] d, logic [7:0] x1, logic [7:0] x2);
    logic [19:0] w = '0;
    int p = 19;
    if (!md) begin
      w[p] = s; p--;
      if (rh) begin w[p] = h; p--; end
      for (int k = (rh ? 1 : 0); k >= 0; k--) begin w[p] = dinb ? 1'b0 : d[k]; p--; end
      for (int k = 7; k >= 0; k--) begin w[p] = dinb ? d[k] : x1[k]; p--; end
    end else begin
      for (int k = (rh ? 3 : 1); k >= 0; k--) begin w[p] = d[k]; p--; end
      for (int k = 7; k >= 0; k--) begin w[p] = x1[k]; p--; end
    end
    if (rh) for (int k = 7; k >= 0; k--) begin w[p] = x2[k]; p--; end
    return w;
  endfunction

  function automatic logic [1:0] exp_sym();
    bit b;
    if (!m_started || line_dis || diag_off) return 2'b00;
    b = m_word[19 - m_idx];
    if (!m_phase) return b ? 2'b01 : 2'b10;
    return b ? 2'b10 : 2'b01;
  endfunction

  task automatic step(string tag);
    string t;
    logic [1:0] prev;
    half_en = 1'b1;
    @(posedge clk);
    m_fs = 0;
    if (!m_started || (m_phase && m_idx == m_len - 1)) begin
      m_sync    = ~m_sync;
      m_word    = build(rate_hi, unframed, d_in_b1, m_sync, hk, d_chan, b1, b2);
      m_len     = rate_hi ? 20 : 10;
      m_mod     = unframed;
      m_idx     = 0;
      m_phase   = 0;
      m_started = 1;
      m_fs      = 1;
    end else if (!m_phase) begin
      m_phase = 1;
    end else begin
      m_phase = 0;
      m_idx++;
    end
    @(negedge clk);
    half_en = 1'b0;
    chk("R9", fs, m_fs);
    t = tag;
    if (line_dis || diag_off) t = "R10";
    else if (m_idx == 0 && !m_mod) t = "R7";
    else if (m_phase) t = "R2";
    chk(t, sym, exp_sym());
    // R11: idle clocks between strobes
    repeat (gap_ctr % 3) begin
      prev = sym;
      @(negedge clk);
      chk("R11", sym, prev);
      chk("R11", fs, 1'b0);
    end
    gap_ctr++;
  endtask

  task automatic run_frame(string tag, bit scramble, bit dis_test);
    string t = tag;
    do step(t); while (!m_fs);
    for (int i = 1; i < 2 * m_len; i++) begin
      if (scramble && i == m_len) begin
        // R8: mid-frame input changes must not reach this frame
        rate_hi = ~rate_hi; unframed = ~unframed; d_in_b1 = ~d_in_b1; hk = ~hk;
        d_chan = $urandom; b1 = $urandom; b2 = $urandom;
        t = "R8";
      end
      if (dis_test && i == 3) begin
        line_dis = 1'b1; #1;
        chk("R10", sym, 2'b00);
      end
      if (dis_test && i == 6) begin line_dis = 1'b0; diag_off = 1'b1; end
      if (dis_test && i == 9) diag_off = 1'b0;
      step(t);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] pat [6];
    pat[0] = 8'h00; pat[1] = 8'hFF; pat[2] = 8'hA5;
    pat[3] = 8'h5A; pat[4] = 8'h81; pat[5] = 8'h3C;
    repeat (3) @(negedge clk);
    chk("R1", sym, 2'b00);
    chk("R1", fs, 1'b0);
    rst_ni = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk("R1", sym, 2'b00);
      chk("R1", fs, 1'b0);
    end
    // sweep rate, mode and D-into-B1 across byte patterns (R3..R6)
    for (int cfg = 0; cfg < 8; cfg++) begin
      for (int p = 0; p < 6; p++) begin
        string tag;
        rate_hi  = cfg[0];
        unframed = cfg[1];
        d_in_b1  = cfg[2];
        b1       = pat[p];
        b2       = ~pat[(p + 2) % 6];
        d_chan   = pat[(p + 3) % 6] ^ 8'h96;
        hk       = p[0];
        if (unframed) tag = "R6";
        else if (d_in_b1) tag = "R5";
        else if (rate_hi) tag = "R4";
        else tag = "R3";
        run_frame(tag, 1'b0, 1'b0);
      end
    end
    for (int k = 0; k < 6; k++) begin
      rate_hi = k[0]; unframed = k[1]; d_in_b1 = k[2];
      b1 = $urandom; b2 = $urandom; d_chan = $urandom; hk = $urandom;
      run_frame("R8", 1'b1, 1'b0);
    end
    for (int k = 0; k < 4; k++) begin
      rate_hi = k[0]; unframed = k[1]; d_in_b1 = 1'b0;
      b1 = $urandom; b2 = $urandom; d_chan = $urandom; hk = $urandom;
      run_frame("R10", 1'b0, 1'b1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule